// File: doc/BRIEF.md
# Eight-bit GPIO port with standby pin isolation

This block controls a general-purpose I/O port of eight pins. Three per-pin registers set its behaviour: an output level, a direction (1 = drive) and an internal pull-up enable. A fourth register holds a single isolation-select bit. Software reads and writes these registers over a small synchronous register bus that has per-byte write enables. For each pin the block drives the pad's output enable, output value and pull-up enable. It also passes the pad's input level to the core through a gate.

A power controller raises a standby flag while the device sits in a deep sleep state. When the isolation-select bit is 1, every pad is released to high impedance during standby, whatever the direction register holds. Input paths are also forced to read low so that floating pads cannot leak. The exception is any pin that an external interrupt block has enabled as a wake source: its input stays live. When the isolation-select bit is 0, standby changes nothing on the pins. Whenever a pin actively drives low, its pull-up is switched off.

Top module: `gpio_stby_port`

## Requirements
- R1: After reset the level, direction, pull-up and control registers all read 0. pad_oe is 0 and pad_pu is 0 on every pin.
- R2: Register writes take effect on the clock edge where bus_wr is 1. They update only the bytes whose bus_be bit is 1. A write with bus_be = 0 leaves the register unchanged. Addresses: 0 = level, 1 = direction, 2 = pull-up, 3 = control (bit 0 = isolation select).
- R3: Outside isolation, pad_oe equals the direction register and pad_out equals the level register.
- R4: Reading address 0 returns, per bit, the level register where direction is 1 and the gated input where direction is 0.
- R5: A pin with its pull-up bit set, and not driving low, has pad_pu = 1.
- R6: A pin with pad_oe = 1 and pad_out = 0 has pad_pu = 0, whatever its pull-up bit.
- R7: With isolation select = 1, pad_oe is 0 on all pins from the first clock edge at which stby_active is sampled high.
- R8: Under that isolation, core_in is 0 on every pin whose wake_irq_en bit is 0. Pins with wake_irq_en = 1 pass pad_in through.
- R9: With isolation select = 0, stby_active has no effect on pad_oe, pad_pu or core_in.
- R10: During isolation, pad_pu equals the pull-up register bit, even on pins whose level bit is 0.
- R11: On the first clock edge at which stby_active is sampled low, normal drive and input resume, and the register contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_be | input | 1 | Per-byte write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on bus_addr) |
| stby_active | input | 1 | Device is in a deep standby state |
| wake_irq_en | input | 8 | Per-pin wake interrupt enabled |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pad_pu | output | 8 | Pad pull-up enable |
| core_in | output | 8 | Gated input levels to the core |

## Verification
The bench drives a mix of input and output pins and checks pull-up suppression on exactly the pins that drive low. A design that keyed the suppression on the level bit alone would switch off pull-ups on input pins. Entering standby is checked both just before and just after the capturing edge, which catches a design that isolates combinationally or a cycle late. With wake pins mixed in, it also catches a design that clamps the wake pins too. The bench also checks that pull-ups stay on in isolation for pins whose level bit is 0, that standby has no effect when isolation select is 0, and that a masked byte write is ignored.

// File: rtl/gpio_stby_pkg.sv
package gpio_stby_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LEVEL = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_PULL  = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_stby_regs.sv
module gpio_stby_regs
    import gpio_stby_pkg::*;
#(
    parameter int unsigned W = 8,
    localparam int unsigned NB = (W + 7) / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NB-1:0]     be,
    input  logic [W-1:0]      wdata,
    input  logic              stby_req,
    output logic [W-1:0]      level_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      pull_q,
    output logic              iso_sel_q,
    output logic              stby_q
);
    typedef struct packed {
        logic [W-1:0] level;
        logic [W-1:0] dir;
        logic [W-1:0] pull;
        logic         iso_sel;
        logic         stby;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stby = stby_req;
        if (wr_en) begin
            for (int i = 0; i < int'(W); i++) begin
                if (be[i / 8]) begin
                    case (reg_sel_e'(addr))
                        SEL_LEVEL: st_d.level[i] = wdata[i];
                        SEL_DIR:   st_d.dir[i]   = wdata[i];
                        SEL_PULL:  st_d.pull[i]  = wdata[i];
                        default:   ;
                    endcase
                end
            end
            if (reg_sel_e'(addr) == SEL_CTRL && be[0]) begin
                st_d.iso_sel = wdata[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_q   = st_q.level;
    assign dir_q     = st_q.dir;
    assign pull_q    = st_q.pull;
    assign iso_sel_q = st_q.iso_sel;
    assign stby_q    = st_q.stby;

    // R2: a write with no byte enabled leaves the registers untouched
    p_masked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && be == '0) |=> (level_q == $past(level_q) && dir_q == $past(dir_q)
                                 && pull_q == $past(pull_q) && iso_sel_q == $past(iso_sel_q)));
endmodule

// File: rtl/gpio_stby_pin.sv
module gpio_stby_pin (
    input  logic level,
    input  logic dir,
    input  logic pull,
    input  logic isolate,
    input  logic wake_en,
    input  logic pad_in,
    output logic pad_oe,
    output logic pad_out,
    output logic pad_pu,
    output logic core_in,
    output logic rd_bit
);
    logic drive;
    logic drive_low;
    logic clamp;

    always_comb begin
        drive     = dir & ~isolate;
        drive_low = drive & ~level;
        clamp     = isolate & ~wake_en;
        pad_oe    = drive;
        pad_out   = level;
        pad_pu    = pull & ~drive_low;
        core_in   = pad_in & ~clamp;
        rd_bit    = dir ? level : core_in;
    end
endmodule

// File: rtl/gpio_stby_port.sv
module gpio_stby_port
    import gpio_stby_pkg::*;
#(
    parameter int unsigned W = 8,
    localparam int unsigned NB = (W + 7) / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NB-1:0]     bus_be,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              stby_active,
    input  logic [W-1:0]      wake_irq_en,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_pu,
    output logic [W-1:0]      core_in
);
    logic [W-1:0] level_q, dir_q, pull_q, rd_level;
    logic         iso_sel_q, stby_q, isolate;

    gpio_stby_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .be        (bus_be),
        .wdata     (bus_wdata),
        .stby_req  (stby_active),
        .level_q   (level_q),
        .dir_q     (dir_q),
        .pull_q    (pull_q),
        .iso_sel_q (iso_sel_q),
        .stby_q    (stby_q)
    );

    assign isolate = iso_sel_q & stby_q;

    for (genvar g = 0; g < int'(W); g++) begin : g_pin
        gpio_stby_pin u_pin (
            .level   (level_q[g]),
            .dir     (dir_q[g]),
            .pull    (pull_q[g]),
            .isolate (isolate),
            .wake_en (wake_irq_en[g]),
            .pad_in  (pad_in[g]),
            .pad_oe  (pad_oe[g]),
            .pad_out (pad_out[g]),
            .pad_pu  (pad_pu[g]),
            .core_in (core_in[g]),
            .rd_bit  (rd_level[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (reg_sel_e'(bus_addr))
            SEL_LEVEL: bus_rdata = rd_level;
            SEL_DIR:   bus_rdata = dir_q;
            SEL_PULL:  bus_rdata = pull_q;
            SEL_CTRL:  bus_rdata[0] = iso_sel_q;
            default:   bus_rdata = '0;
        endcase
    end

    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (reg_sel_e'(bus_addr) == SEL_CTRL);

    // R7: isolation releases every pad after the capturing edge
    p_iso_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_active && iso_sel_q && !ctrl_wr) |=> (pad_oe == '0));

    // R8: only wake-enabled pins may show a high input under isolation
    p_iso_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_active && iso_sel_q && !ctrl_wr) |=> ((core_in & ~wake_irq_en) == '0));

    // R6: no pull-up on a pin that drives low
    p_pull_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~pad_out & pad_pu) == '0));

    // R9: with isolation select clear the pads follow the direction register
    p_no_iso_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!iso_sel_q) |-> (pad_oe == dir_q));
endmodule

// File: tb/test_gpio_stby_port.sv
`timescale 1ns/1ps
module test_gpio_stby_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [0:0] bus_be = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       stby_active = 1'b0;
    logic [7:0] wake_irq_en = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_pu, core_in;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gpio_stby_port i_gpio_stby_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stby_active(stby_active), .wake_irq_en(wake_irq_en), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .core_in(core_in)
    );

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, logic be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Model values used across scenarios
    localparam logic [7:0] DIR = 8'hA5, LVL = 8'h0F, PIN = 8'h3C;

    task automatic t_reset;
        logic [7:0] d;
        rd(2'd1, d); chk("R1", "dir reg", d, 8'h00);
        rd(2'd2, d); chk("R1", "pull reg", d, 8'h00);
        rd(2'd3, d); chk("R1", "ctrl reg", d, 8'h00);
        chk("R1", "pad_oe", pad_oe, 8'h00);
        chk("R1", "pad_pu", pad_pu, 8'h00);
    endtask

    task automatic t_write;
        logic [7:0] d;
        wr(2'd1, 8'hFF, 1'b0);
        rd(2'd1, d); chk("R2", "masked dir write", d, 8'h00);
        wr(2'd1, DIR, 1'b1);
        rd(2'd1, d); chk("R2", "dir write", d, DIR);
        wr(2'd0, LVL, 1'b1);
        chk("R3", "pad_oe", pad_oe, DIR);
        chk("R3", "pad_out", pad_out, LVL);
    endtask

    task automatic t_read;
        logic [7:0] d;
        pad_in = PIN;
        rd(2'd0, d);
        chk("R4", "level read", d, (DIR & LVL) | (~DIR & PIN));
    endtask

    task automatic t_pull;
        logic [7:0] low;
        low = DIR & ~LVL;
        wr(2'd2, 8'hFF, 1'b1);
        chk("R5", "pull on idle pins", pad_pu & ~low, ~low);
        chk("R6", "pull off on low-driving pins", pad_pu & low, 8'h00);
    endtask

    task automatic t_isolate;
        pad_in = 8'hFF;
        wake_irq_en = 8'h81;
        wr(2'd3, 8'h01, 1'b1);
        @(negedge clk);
        stby_active = 1'b1;
        #1 chk("R7", "oe before capture edge", pad_oe, DIR);
        @(posedge clk); #1;
        chk("R7", "oe isolated", pad_oe, 8'h00);
        chk("R8", "input clamp", core_in, 8'h81);
        chk("R10", "pull follows enable", pad_pu, 8'hFF);
    endtask

    task automatic t_exit;
        logic [7:0] d;
        @(negedge clk);
        stby_active = 1'b0;
        @(posedge clk); #1;
        chk("R11", "oe restored", pad_oe, DIR);
        chk("R11", "input restored", core_in, 8'hFF);
        rd(2'd1, d); chk("R11", "dir kept", d, DIR);
        rd(2'd2, d); chk("R11", "pull kept", d, 8'hFF);
    endtask

    task automatic t_no_iso;
        wr(2'd3, 8'h00, 1'b1);
        wake_irq_en = 8'h00;
        pad_in = PIN;
        @(negedge clk);
        stby_active = 1'b1;
        @(posedge clk); #1;
        chk("R9", "oe unchanged", pad_oe, DIR);
        chk("R9", "input unchanged", core_in, PIN);
        chk("R9", "pull unchanged", pad_pu, ~(DIR & ~LVL));
        @(negedge clk);
        stby_active = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_read();
        t_pull();
        t_isolate();
        t_exit();
        t_no_iso();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule